// File: doc/BRIEF.md
# Tagged Serial Character Receiver

This block receives asynchronous serial characters from a single line, sampling it on a 16x oversample tick that comes from a baud generator outside the block. A frame-format input selects the character size, the parity mode and the stop-bit length. Each character is stored in a small receive buffer together with two tags: a parity-error tag and a framing-error tag. Software reads the head of the buffer as one extended word, and a read strobe removes that entry.

A data-valid status stays high while the buffer holds at least one character. Two sticky interrupt flags record that a character arrived and that a character was lost because the buffer was full. Each flag has its own set, clear and enable inputs. A line break is not reported separately. It shows up as a character whose data bits are all zero and whose framing-error tag is set. After such a character, the receiver waits for the line to return high before it looks for the next start bit.

Top module: `serial_rx_tagger`

## Requirements
- R1: After reset, rx_valid, both flags and irq are 0, and the receiver is disabled, so line activity stores nothing until it is enabled.
- R2: frame_cfg[3:0] holds the character length minus 3. The values 2 to 6 give 5 to 9 bits; lower values clamp to 5 bits and higher values to 9 bits. Bits arrive LSB first. They are right-aligned in rx_word[8:0], and rx_word[13:9] read as zero.
- R3: frame_cfg[9:8] selects parity: 00 for none, 10 for even, 11 for odd (01 behaves as none). When the received parity bit does not match, rx_word[14] is set.
- R4: rx_word[15] is set when the first stop bit is sampled low. A second stop bit (frame_cfg[13:12] = 11) is never checked, so a start bit may follow in its place.
- R5: With frame_cfg[13:12] = 00 (half stop bit), the stop level is sampled 12 ticks after the midpoint of the last bit. Characters sent back to back with half-length stop bits are decoded without errors.
- R6: A line held low through a whole character gives a stored word with data 0 and rx_word[15] = 1. No new character starts until the line has been high.
- R7: The start bit is checked 8 ticks after the falling edge. If the line is high at that point, the start is discarded and nothing is stored.
- R8: The buffer holds 2 characters. rx_valid is high while it is not empty. rx_word shows the oldest entry, and a pulse on rd_pop removes it. rd_pop on an empty buffer has no effect.
- R9: A character that arrives while the buffer is full is discarded, sets flags[1] (overflow), and leaves the stored entries unchanged.
- R10: A pulse on cmd_rx_on enables reception and a pulse on cmd_rx_off disables it. If both pulse in the same cycle, the receiver ends up disabled. A disabled receiver stores nothing.
- R11: flags[0] is set when a character is stored and flags[1] on overflow. The flags are sticky. flag_set sets a flag and flag_clr clears it; a set or an event in the same cycle wins over a clear. irq is high when any flag is set whose flag_en bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | 16x oversample tick, one clock wide |
| rxd | input | 1 | Serial line, idle high |
| frame_cfg | input | 16 | Frame format: length [3:0], parity [9:8], stop [13:12] |
| cmd_rx_on | input | 1 | Receiver enable strobe |
| cmd_rx_off | input | 1 | Receiver disable strobe |
| rd_pop | input | 1 | Remove the head entry of the buffer |
| rx_word | output | 16 | Head entry: data [8:0], parity tag [14], framing tag [15] |
| rx_valid | output | 1 | Buffer holds at least one character |
| flag_set | input | 2 | Write-one-to-set for the flags |
| flag_clr | input | 2 | Write-one-to-clear for the flags |
| flag_en | input | 2 | Interrupt enable mask |
| flags | output | 2 | Sticky flags: [0] data stored, [1] overflow |
| irq | output | 1 | OR of the enabled flags |

## Verification
Four properties are checked on every cycle: a full buffer keeps its head word stable until a pop; rx_valid drops only after a pop; a set flag stays set until it is cleared; and a disabled receiver emits no character. Only the directed scenarios can show that characters decode correctly. They cover the bit-length, parity and stop-length decoding, break detection, glitch rejection and which character is lost on overflow. All of these depend on serial waveforms spread over many ticks, which the bench builds and compares against words it computes itself.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DATA_MAX = 9;
    localparam int WORD_W   = 16;
    localparam int NFLAG    = 2;
    localparam int FLG_DV   = 0;
    localparam int FLG_OVF  = 1;

    typedef struct packed {
        logic                ferr;
        logic                perr;
        logic [DATA_MAX-1:0] data;
    } rx_char_t;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_on;
        logic       par_odd;
        logic       half_stop;
    } frame_fmt_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
    } rx_state_t;

    function automatic frame_fmt_t decode_frame(input logic [15:0] cfg);
        frame_fmt_t f;
        logic [4:0] raw;
        raw = {1'b0, cfg[3:0]} + 5'd3;
        if (raw < 5'd5)      f.nbits = 4'd5;
        else if (raw > 5'd9) f.nbits = 4'd9;
        else                 f.nbits = raw[3:0];
        f.par_on    = cfg[9];
        f.par_odd   = cfg[8];
        f.half_stop = (cfg[13:12] == 2'b00);
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input rx_char_t c);
        return {c.ferr, c.perr, 1'b0, 4'b0000, c.data};
    endfunction

endpackage

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick,
    input  logic       rxd,
    input  frame_fmt_t fmt,
    output logic       chr_stb,
    output rx_char_t   chr
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] HALF_LIM = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] HSTP_LIM = CNT_W'((OSR*3)/4 - 1);

    rx_state_t           state;
    logic [CNT_W-1:0]    cnt;
    logic [3:0]          bitn;
    logic [DATA_MAX-1:0] sh;
    logic                pbit;
    logic [DATA_MAX-1:0] aligned;
    logic [3:0]          shamt;
    logic                perr;

    always_comb begin
        shamt   = 4'(DATA_MAX) - fmt.nbits;
        aligned = sh >> shamt;
        perr    = fmt.par_on && ((^aligned ^ pbit) != fmt.par_odd);
    end

    always_ff @(posedge clk) begin
        chr_stb <= 1'b0;
        if (rst || !run) begin
            state <= ST_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            sh    <= '0;
            pbit  <= 1'b0;
            chr   <= '0;
        end else if (tick) begin
            unique case (state)
                ST_IDLE: if (!rxd) begin
                    state <= ST_START;
                    cnt   <= '0;
                end
                ST_START: if (cnt == HALF_LIM) begin
                    state <= rxd ? ST_IDLE : ST_DATA;
                    cnt   <= '0;
                    bitn  <= '0;
                end else cnt <= cnt + 1'b1;
                ST_DATA: if (cnt == FULL_LIM) begin
                    cnt <= '0;
                    sh  <= {rxd, sh[DATA_MAX-1:1]};
                    if (bitn == fmt.nbits - 4'd1)
                        state <= fmt.par_on ? ST_PAR : ST_STOP;
                    else
                        bitn <= bitn + 4'd1;
                end else cnt <= cnt + 1'b1;
                ST_PAR: if (cnt == FULL_LIM) begin
                    cnt   <= '0;
                    pbit  <= rxd;
                    state <= ST_STOP;
                end else cnt <= cnt + 1'b1;
                ST_STOP: if (cnt == (fmt.half_stop ? HSTP_LIM : FULL_LIM)) begin
                    cnt      <= '0;
                    chr_stb  <= 1'b1;
                    chr.data <= aligned;
                    chr.perr <= perr;
                    chr.ferr <= !rxd;
                    state    <= rxd ? ST_IDLE : ST_HOLD;
                end else cnt <= cnt + 1'b1;
                ST_HOLD: if (rxd) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srx_buffer.sv
module srx_buffer
    import srx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  rx_char_t                 din,
    input  logic                     pop,
    output rx_char_t                 head,
    output logic [$clog2(DEPTH+1)-1:0] fill,
    output logic                     stored,
    output logic                     lost
);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FILL_W = $clog2(DEPTH+1);

    rx_char_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_pop, full;

    always_comb begin
        full   = (fill == FILL_W'(DEPTH));
        do_pop = pop && (fill != '0);
        stored = push && (!full || do_pop);
        lost   = push && !stored;
        head   = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (stored)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (stored && !do_pop)      fill <= fill + 1'b1;
            else if (do_pop && !stored) fill <= fill - 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (stored && wr_ptr == PTR_W'(i))
                mem[i] <= din;
        end
    end
endmodule

// File: rtl/srx_flags.sv
module srx_flags
    import srx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] evt,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    input  logic [NFLAG-1:0] en,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                   flags[i] <= 1'b0;
            else if (evt[i] || set[i]) flags[i] <= 1'b1;
            else if (clr[i])           flags[i] <= 1'b0;
        end
    end

    assign irq = |(flags & en);
endmodule

// File: rtl/serial_rx_tagger.sv
module serial_rx_tagger
    import srx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     os_tick,
    input  logic                     rxd,
    input  logic [15:0]              frame_cfg,
    input  logic                     cmd_rx_on,
    input  logic                     cmd_rx_off,
    input  logic                     rd_pop,
    output logic [WORD_W-1:0]        rx_word,
    output logic                     rx_valid,
    input  logic [NFLAG-1:0]         flag_set,
    input  logic [NFLAG-1:0]         flag_clr,
    input  logic [NFLAG-1:0]         flag_en,
    output logic [NFLAG-1:0]         flags,
    output logic                     irq
);
    localparam int FILL_W = $clog2(DEPTH+1);

    logic              rx_on;
    logic              run;
    logic              chr_stb;
    rx_char_t          chr, head;
    logic [FILL_W-1:0] fill_cnt;
    logic              stored, lost;
    logic [NFLAG-1:0]  evt;

    always_ff @(posedge clk) begin
        if (rst)             rx_on <= 1'b0;
        else if (cmd_rx_off) rx_on <= 1'b0;
        else if (cmd_rx_on)  rx_on <= 1'b1;
    end

    assign run = rx_on && !cmd_rx_off;

    srx_framer #(.OSR(OSR)) u_framer (
        .clk(clk), .rst(rst), .run(run), .tick(os_tick), .rxd(rxd),
        .fmt(decode_frame(frame_cfg)), .chr_stb(chr_stb), .chr(chr)
    );

    srx_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst(rst), .push(chr_stb), .din(chr), .pop(rd_pop),
        .head(head), .fill(fill_cnt), .stored(stored), .lost(lost)
    );

    always_comb begin
        evt          = '0;
        evt[FLG_DV]  = stored;
        evt[FLG_OVF] = lost;
    end

    srx_flags u_flags (
        .clk(clk), .rst(rst), .evt(evt), .set(flag_set), .clr(flag_clr),
        .en(flag_en), .flags(flags), .irq(irq)
    );

    assign rx_valid = (fill_cnt != '0);
    assign rx_word  = rx_valid ? pack_word(head) : '0;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DEPTH  = 2,
    parameter int FILL_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              rd_pop,
    input logic [15:0]       rx_word,
    input logic [1:0]        flags,
    input logic [1:0]        flag_clr,
    input logic              chr_stb,
    input logic              rx_on,
    input logic [FILL_W-1:0] fill
);
    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rx_valid && flags == 2'b00));

    // R8
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rd_pop) |=> rx_valid);

    // R9
    full_head_chk: assert property (@(posedge clk) disable iff (rst)
        (fill == FILL_W'(DEPTH) && !rd_pop) |=> $stable(rx_word));

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_on |-> !chr_stb);

    // R11
    dv_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !flag_clr[0]) |=> flags[0]);

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[1] && !flag_clr[1]) |=> flags[1]);
endmodule

bind serial_rx_tagger srx_checker #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rd_pop(rd_pop),
    .rx_word(rx_word), .flags(flags), .flag_clr(flag_clr),
    .chr_stb(chr_stb), .rx_on(rx_on), .fill(fill_cnt)
);

// File: tb/serial_rx_tagger_test.sv
module serial_rx_tagger_test;
    localparam int BITC = 64;   // 4 clocks per tick x 16 ticks

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        os_tick = 1'b0;
    logic        rxd = 1'b1;
    logic [15:0] frame_cfg = 16'h1005;
    logic        cmd_rx_on = 1'b0, cmd_rx_off = 1'b0, rd_pop = 1'b0;
    logic [1:0]  flag_set = '0, flag_clr = '0, flag_en = '0;
    logic [15:0] rx_word;
    logic        rx_valid, irq;
    logic [1:0]  flags;
    logic [1:0]  div = '0;
    int          checks = 0, errors = 0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        div     <= div + 2'd1;
        os_tick <= (div == 2'd3);
    end

    serial_rx_tagger uut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .frame_cfg(frame_cfg), .cmd_rx_on(cmd_rx_on), .cmd_rx_off(cmd_rx_off),
        .rd_pop(rd_pop), .rx_word(rx_word), .rx_valid(rx_valid),
        .flag_set(flag_set), .flag_clr(flag_clr), .flag_en(flag_en),
        .flags(flags), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] wexp(input logic [8:0] d, input logic pe, input logic fe);
        return {fe, pe, 5'b0, d};
    endfunction

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pm: 0 none, 2 even, 3 odd
    task automatic send(input logic [8:0] d, input int nb, input int pm,
                        input bit badpar, input bit stop_lvl, input int stop_clk,
                        input int gap_clk);
        logic p;
        p = 1'b0;
        @(negedge clk);
        rxd = 1'b0; clks(BITC);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i]; p ^= d[i]; clks(BITC);
        end
        if (pm != 0) begin
            rxd = (pm == 3) ? ~p : p;
            if (badpar) rxd = ~rxd;
            clks(BITC);
        end
        rxd = stop_lvl; clks(stop_clk);
        rxd = 1'b1; clks(gap_clk);
    endtask

    task automatic pop;
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
    endtask

    task automatic strobe_on(input bit on, input bit off);
        @(negedge clk); cmd_rx_on = on; cmd_rx_off = off;
        @(negedge clk); cmd_rx_on = 1'b0; cmd_rx_off = 1'b0;
    endtask

    task automatic clr_flags;
        @(negedge clk); flag_clr = 2'b11;
        @(negedge clk); flag_clr = 2'b00;
    endtask

    task automatic t_reset;
        rst = 1'b1; clks(4); rst = 1'b0; clks(1);
        chk("R1 valid", {15'd0, rx_valid}, 16'd0);
        chk("R1 flags", {14'd0, flags}, 16'd0);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        send(9'h055, 8, 0, 0, 1, BITC, BITC);
        chk("R1 disabled after reset", {15'd0, rx_valid}, 16'd0);
        strobe_on(1, 0);
    endtask

    task automatic t_lengths;
        frame_cfg = 16'h1005;
        send(9'h0A5, 8, 0, 0, 1, BITC, BITC);
        chk("R2 8-bit valid", {15'd0, rx_valid}, 16'd1);
        chk("R2 8-bit word", rx_word, wexp(9'h0A5, 0, 0));
        pop;
        chk("R8 empty after pop", {15'd0, rx_valid}, 16'd0);
        frame_cfg = 16'h1002;
        send(9'h1F6, 5, 0, 0, 1, BITC, BITC);
        chk("R2 5-bit word", rx_word, wexp(9'h016, 0, 0)); pop;
        frame_cfg = 16'h1004;
        send(9'h05B, 7, 0, 0, 1, BITC, BITC);
        chk("R2 7-bit word", rx_word, wexp(9'h05B, 0, 0)); pop;
        frame_cfg = 16'h1006;
        send(9'h1C3, 9, 0, 0, 1, BITC, BITC);
        chk("R2 9-bit word", rx_word, wexp(9'h1C3, 0, 0)); pop;
        frame_cfg = 16'h100F;
        send(9'h12D, 9, 0, 0, 1, BITC, BITC);
        chk("R2 clamp to 9 bits", rx_word, wexp(9'h12D, 0, 0)); pop;
    endtask

    task automatic t_parity;
        frame_cfg = 16'h1205;
        send(9'h0B7, 8, 2, 0, 1, BITC, BITC);
        chk("R3 even ok", rx_word, wexp(9'h0B7, 0, 0)); pop;
        send(9'h0B7, 8, 2, 1, 1, BITC, BITC);
        chk("R3 even bad", rx_word, wexp(9'h0B7, 1, 0)); pop;
        frame_cfg = 16'h1305;
        send(9'h031, 8, 3, 0, 1, BITC, BITC);
        chk("R3 odd ok", rx_word, wexp(9'h031, 0, 0)); pop;
        send(9'h031, 8, 3, 1, 1, BITC, BITC);
        chk("R3 odd bad", rx_word, wexp(9'h031, 1, 0)); pop;
    endtask

    task automatic t_stop;
        frame_cfg = 16'h1005;
        send(9'h03C, 8, 0, 0, 0, BITC, BITC);
        chk("R4 low stop tags frame", rx_word, wexp(9'h03C, 0, 1)); pop;
        frame_cfg = 16'h3005;
        send(9'h081, 8, 0, 0, 1, BITC, 0);
        send(9'h07E, 8, 0, 0, 1, BITC, BITC);
        chk("R4 two-stop first", rx_word, wexp(9'h081, 0, 0)); pop;
        chk("R4 two-stop second", rx_word, wexp(9'h07E, 0, 0)); pop;
    endtask

    task automatic t_half;
        frame_cfg = 16'h0005;
        send(9'h0C6, 8, 0, 0, 1, BITC/2, 0);
        send(9'h019, 8, 0, 0, 1, BITC/2, BITC);
        chk("R5 half-stop first", rx_word, wexp(9'h0C6, 0, 0)); pop;
        chk("R5 half-stop second", rx_word, wexp(9'h019, 0, 0)); pop;
    endtask

    task automatic t_break;
        frame_cfg = 16'h1005;
        @(negedge clk); rxd = 1'b0; clks(BITC * 13);
        rxd = 1'b1; clks(BITC);
        chk("R6 break word", rx_word, wexp(9'h000, 0, 1));
        pop;
        chk("R6 single entry", {15'd0, rx_valid}, 16'd0);
        send(9'h0E4, 8, 0, 0, 1, BITC, BITC);
        chk("R6 char after break", rx_word, wexp(9'h0E4, 0, 0)); pop;
    endtask

    task automatic t_glitch;
        @(negedge clk); rxd = 1'b0; clks(16);
        rxd = 1'b1; clks(BITC * 12);
        chk("R7 glitch ignored", {15'd0, rx_valid}, 16'd0);
    endtask

    task automatic t_overflow;
        clr_flags;
        send(9'h011, 8, 0, 0, 1, BITC, BITC);
        send(9'h022, 8, 0, 0, 1, BITC, BITC);
        chk("R9 no overflow at two", {14'd0, flags}, 16'd1);
        send(9'h033, 8, 0, 0, 1, BITC, BITC);
        chk("R9 overflow flag", {14'd0, flags}, 16'd3);
        chk("R9 head kept", rx_word, wexp(9'h011, 0, 0)); pop;
        chk("R8 second entry", rx_word, wexp(9'h022, 0, 0)); pop;
        chk("R9 third discarded", {15'd0, rx_valid}, 16'd0);
        pop;
        send(9'h044, 8, 0, 0, 1, BITC, BITC);
        chk("R8 pop on empty harmless", rx_word, wexp(9'h044, 0, 0));
        chk("R8 one entry", {15'd0, rx_valid}, 16'd1);
        pop;
    endtask

    task automatic t_enable;
        strobe_on(1, 1);
        send(9'h066, 8, 0, 0, 1, BITC, BITC);
        chk("R10 off wins", {15'd0, rx_valid}, 16'd0);
        strobe_on(1, 0);
        send(9'h077, 8, 0, 0, 1, BITC, BITC);
        chk("R10 re-enabled", rx_word, wexp(9'h077, 0, 0)); pop;
        strobe_on(0, 1);
        send(9'h088, 8, 0, 0, 1, BITC, BITC);
        chk("R10 disabled", {15'd0, rx_valid}, 16'd0);
        strobe_on(1, 0);
    endtask

    task automatic t_flags;
        clr_flags;
        chk("R11 cleared", {14'd0, flags}, 16'd0);
        flag_en = 2'b10;
        send(9'h05A, 8, 0, 0, 1, BITC, BITC);
        chk("R11 dv flag", {14'd0, flags}, 16'd1);
        chk("R11 masked irq", {15'd0, irq}, 16'd0);
        pop; clks(2);
        chk("R11 sticky after pop", {14'd0, flags}, 16'd1);
        @(negedge clk); flag_set = 2'b10; flag_clr = 2'b10;
        @(negedge clk); flag_set = 2'b00; flag_clr = 2'b00;
        chk("R11 set beats clear", {14'd0, flags}, 16'd3);
        chk("R11 irq enabled", {15'd0, irq}, 16'd1);
        @(negedge clk); flag_clr = 2'b10;
        @(negedge clk); flag_clr = 2'b00;
        chk("R11 clear", {14'd0, flags}, 16'd1);
        chk("R11 irq drops", {15'd0, irq}, 16'd0);
        flag_en = 2'b01; clks(1);
        chk("R11 irq from dv", {15'd0, irq}, 16'd1);
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_lengths;
                t_parity;
                t_stop;
                t_half;
                t_break;
                t_glitch;
                t_overflow;
                t_enable;
                t_flags;
            end
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule